// File: doc/BRIEF.md
# Configurable Interrupt Controller

This block gathers up to 32 asynchronous interrupt sources and turns them into two request lines for a processor: a normal request and a fast request. Each source has its own settings. One bit enables it. One bit picks the active sense, which is high or low for a level source and rising or falling for an edge source. One bit chooses level or edge detection. One bit steers the source to the fast line. An edge source stays pending in a sticky latch until software clears it. A level source shows the state of its input after synchronization.

Software reaches the settings and the status through a small synchronous register port. The port uses word addressing, so byte offset = 4 × word address. The controller also gives a registered vector: the index of the highest-numbered source that is pending on the normal path, together with a valid flag. An interrupt handler can branch on this value without scanning the status word.

Top module: `intc_top`

## Requirements
- R1: After reset, the enable, detect-mode and steering registers read 0, and the polarity register reads the POL_RST parameter (default all ones). irq_o, fiq_o and vec_valid_o are 0.
- R2: A source whose detect-mode bit is 0 (level) has raw status 1 exactly while its input equals its polarity bit, whatever its enable bit is. The input is synchronized by two flops, so the change shows on the second rising clock edge after it.
- R3: A source whose detect-mode bit is 1 (edge) sets a sticky raw-status bit when its input moves to the active sense: rising if its polarity bit is 1, falling if it is 0. The bit stays set after the input returns.
- R4: Writing to word 1 (raw status) clears the edge latch of each bit written as 1. Bits written as 0, and sources in level mode, are not changed. If a new edge arrives in the same cycle as a clear, the edge wins. Writes to word 2 (masked status) change nothing.
- R5: Masked status (word 2) equals raw status AND enable.
- R6: irq_o is the OR of the masked bits whose steering bit is 0. fiq_o is the OR of the masked bits whose steering bit is 1.
- R7: vec_o is the index of the most significant bit of (masked AND NOT steering), and vec_valid_o is 1 when that set is non-empty. Both are registered, so they appear one clock edge after the set changes. vec_o is 0 whenever vec_valid_o is 0.
- R8: A read strobe (req_i=1, we_i=0) returns the register in rdata_o after the next rising clock edge, and rdata_o holds its value otherwise. The word map is: 0 enable, 1 raw status, 2 masked status, 3 polarity, 4 detect mode, 5 steering. Words 6 and 7 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Asynchronous interrupt source inputs |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register word address |
| wdata_i | input | N_SRC | Write data |
| rdata_o | output | N_SRC | Read data, registered |
| irq_o | output | 1 | Normal request line |
| fiq_o | output | 1 | Fast request line |
| vec_o | output | $clog2(N_SRC) | Highest pending normal source, registered |
| vec_valid_o | output | 1 | vec_o is valid |

## Verification
The assertions treat the source inputs as slow signals. An edge is only guaranteed to be seen if the input holds each level for at least three clock cycles, and the sticky-latch check expects the detect-mode bit and any clear write to come only from the register port. The stimulus holds every source level for six cycles or more. It changes polarity and mode only while the sources are stable, and it then clears any latch that the reconfiguration may have set before it applies the pattern under test. Register strobes are single-cycle and are driven on the falling edge, so each access is decoded on exactly one rising edge.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_ENABLE   = 3'd0,
    REG_RAW      = 3'd1,
    REG_MASKED   = 3'd2,
    REG_POLARITY = 3'd3,
    REG_SENSE    = 3'd4,
    REG_STEER    = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/intc_src_cond.sv
`timescale 1ns/1ps
module intc_src_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic clr_i,
  output logic raw_o
);
  logic s1_q, s2_q, prev_q, latch_q;
  logic active, rise;

  assign active = pol_i ? s2_q : ~s2_q;
  assign rise   = active & ~prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q    <= 1'b0;
      s2_q    <= 1'b0;
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      s1_q   <= src_i;
      s2_q   <= s1_q;
      prev_q <= active;
      // new event takes priority over a clear in the same cycle
      if (edge_i && rise) latch_q <= 1'b1;
      else if (clr_i)     latch_q <= 1'b0;
    end
  end

  assign raw_o = edge_i ? latch_q : active;
endmodule

// File: rtl/intc_msb_find.sv
`timescale 1ns/1ps
module intc_msb_find #(
  parameter int unsigned N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input  logic [N_SRC-1:0] pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < N_SRC; i++) begin
      if (pend_i[i]) idx_o = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
endmodule

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
#(
  parameter int unsigned      N_SRC   = 32,
  parameter logic [N_SRC-1:0] POL_RST = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  input  logic [N_SRC-1:0]  raw_i,
  input  logic [N_SRC-1:0]  masked_i,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  pol_o,
  output logic [N_SRC-1:0]  sense_o,
  output logic [N_SRC-1:0]  steer_o,
  output logic [N_SRC-1:0]  clr_o,
  output logic [N_SRC-1:0]  rdata_o
);
  reg_sel_e         sel;
  logic             wr, rd;
  logic [N_SRC-1:0] en_q, pol_q, sense_q, steer_q, rdata_q, rd_mux;

  assign sel = reg_sel_e'(addr_i);
  assign wr  = req_i & we_i;
  assign rd  = req_i & ~we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      pol_q   <= POL_RST;
      sense_q <= '0;
      steer_q <= '0;
    end else if (wr) begin
      case (sel)
        REG_ENABLE:   en_q    <= wdata_i;
        REG_POLARITY: pol_q   <= wdata_i;
        REG_SENSE:    sense_q <= wdata_i;
        REG_STEER:    steer_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr && sel == REG_RAW) ? wdata_i : '0;

  always_comb begin
    case (sel)
      REG_ENABLE:   rd_mux = en_q;
      REG_RAW:      rd_mux = raw_i;
      REG_MASKED:   rd_mux = masked_i;
      REG_POLARITY: rd_mux = pol_q;
      REG_SENSE:    rd_mux = sense_q;
      REG_STEER:    rd_mux = steer_q;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign en_o    = en_q;
  assign pol_o   = pol_q;
  assign sense_o = sense_q;
  assign steer_o = steer_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/intc_top.sv
`timescale 1ns/1ps
module intc_top
  import intc_pkg::*;
#(
  parameter int unsigned      N_SRC   = 32,
  parameter logic [N_SRC-1:0] POL_RST = '1,
  localparam int unsigned     IDX_W   = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  wdata_i,
  output logic [N_SRC-1:0]  rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic [IDX_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  logic [N_SRC-1:0] en_w, pol_w, sense_w, steer_w, clr_w;
  logic [N_SRC-1:0] raw_w, masked_w, pend_n_w;
  logic [IDX_W-1:0] idx_w;
  logic             any_w;
  logic [IDX_W-1:0] vec_q;
  logic             vec_valid_q;

  intc_regs #(.N_SRC(N_SRC), .POL_RST(POL_RST)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .raw_i    (raw_w),
    .masked_i (masked_w),
    .en_o     (en_w),
    .pol_o    (pol_w),
    .sense_o  (sense_w),
    .steer_o  (steer_w),
    .clr_o    (clr_w),
    .rdata_o  (rdata_o)
  );

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    intc_src_cond u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .src_i  (src_i[g]),
      .pol_i  (pol_w[g]),
      .edge_i (sense_w[g]),
      .clr_i  (clr_w[g]),
      .raw_o  (raw_w[g])
    );
  end

  assign masked_w = raw_w & en_w;
  assign pend_n_w = masked_w & ~steer_w;
  assign irq_o    = |pend_n_w;
  assign fiq_o    = |(masked_w & steer_w);

  intc_msb_find #(.N_SRC(N_SRC)) u_msb (
    .pend_i (pend_n_w),
    .idx_o  (idx_w),
    .any_o  (any_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      vec_q       <= idx_w;
      vec_valid_q <= any_w;
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;
endmodule

// File: rtl/intc_checker.sv
`timescale 1ns/1ps
module intc_checker #(
  parameter int unsigned  N_SRC = 32,
  localparam int unsigned IDX_W = $clog2(N_SRC)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_i,
  input logic             we_i,
  input logic [2:0]       addr_i,
  input logic [N_SRC-1:0] wdata_i,
  input logic [N_SRC-1:0] rdata_o,
  input logic             irq_o,
  input logic             fiq_o,
  input logic [IDX_W-1:0] vec_o,
  input logic             vec_valid_o,
  input logic [N_SRC-1:0] raw_w,
  input logic [N_SRC-1:0] masked_w,
  input logic [N_SRC-1:0] en_w,
  input logic [N_SRC-1:0] sense_w,
  input logic [N_SRC-1:0] steer_w
);
  logic [N_SRC-1:0] clr_chk, held, pend_chk;

  assign clr_chk  = (req_i && we_i && addr_i == 3'd1) ? wdata_i : '0;
  assign held     = raw_w & sense_w & ~clr_chk;
  assign pend_chk = masked_w & ~steer_w;

  AST_MASKED_SUBSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (masked_w & ~en_w) == '0);  // R5

  AST_FIQ_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> |(masked_w & steer_w & en_w));  // R6

  AST_EDGE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(held) & (raw_w | ~sense_w)) == $past(held)));  // R3

  AST_VALID_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (vec_valid_o == $past(irq_o)));  // R7

  AST_VEC_IS_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (!vec_valid_o || (($past(pend_chk) >> vec_o) == N_SRC'(1))));  // R7

  AST_VEC_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> vec_o == '0);  // R7

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> $stable(rdata_o));  // R8
endmodule

bind intc_top intc_checker #(.N_SRC(N_SRC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .we_i        (we_i),
  .addr_i      (addr_i),
  .wdata_i     (wdata_i),
  .rdata_o     (rdata_o),
  .irq_o       (irq_o),
  .fiq_o       (fiq_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .raw_w       (raw_w),
  .masked_w    (masked_w),
  .en_w        (en_w),
  .sense_w     (sense_w),
  .steer_w     (steer_w)
);

// File: tb/sim_intc_top.sv
`timescale 1ns/1ps
module sim_intc_top;
  localparam int unsigned N = 32;

  typedef struct packed {
    logic [31:0] pol;
    logic [31:0] sense;
    logic [31:0] steer;
    logic [31:0] en;
    logic [31:0] src0;
    logic [31:0] src1;
    logic [31:0] raw;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TABLE [NV] = '{
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_0001, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0000_00FF, 32'h0, 32'h8000_0010, 32'h8000_0010},
    '{32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'h0000_0001},
    '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0000_F000, 32'h0000_F000},
    '{32'h0, 32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hF0FF_FFFF, 32'h0F00_0000},
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_0F00, 32'hFFFF_FFFF, 32'h0, 32'h0000_0F0F, 32'h0000_0F0F},
    '{32'hFFFF_FFFF, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 32'h8000_0000, 32'h8000_0000},
    '{32'hFFFF_FFFF, 32'h0000_FFFF, 32'h0, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0001_01FF, 32'h0001_0100},
    '{32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
    '{32'hAAAA_AAAA, 32'h0, 32'h0, 32'hFFFF_FFFF, 32'h0, 32'h0, 32'h5555_5555},
    '{32'hFFFF_FFFF, 32'h0, 32'h0000_FFFF, 32'h0000_F0F0, 32'h0, 32'h00FF_00FF, 32'h00FF_00FF}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  src_i = '0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [2:0]    addr_i = '0;
  logic [N-1:0]  wdata_i = '0;
  logic [N-1:0]  rdata_o;
  logic          irq_o, fiq_o, vec_valid_o;
  logic [4:0]    vec_o;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  intc_top #(.N_SRC(N)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .src_i(src_i), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .fiq_o(fiq_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    @(posedge clk);
    #1 d = rdata_o;
    @(negedge clk);
    req_i = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic logic [5:0] top_bit(input logic [31:0] v);
    logic [5:0] r;
    r = 6'd0;
    for (int i = 31; i >= 0; i--) begin
      if (v[i] && r == 6'd0) r = 6'd32 | 6'(i);
    end
    return r;
  endfunction

  task automatic finish_run;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    logic [31:0] d, m, pn;
    logic [5:0]  tb;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    #1;
    chk("R1 irq", 32'(irq_o), 32'd0);
    chk("R1 fiq", 32'(fiq_o), 32'd0);
    chk("R1 vec_valid", 32'(vec_valid_o), 32'd0);
    rd(3'd0, d); chk("R1 enable", d, 32'h0);
    rd(3'd4, d); chk("R1 sense", d, 32'h0);
    rd(3'd5, d); chk("R1 steer", d, 32'h0);
    rd(3'd3, d); chk("R1 polarity", d, 32'hFFFF_FFFF);

    // table walk: R2 R3 R5 R6 R7
    for (int k = 0; k < NV; k++) begin
      @(negedge clk) src_i = TABLE[k].src0;
      wr(3'd3, TABLE[k].pol);
      wr(3'd4, TABLE[k].sense);
      wr(3'd5, TABLE[k].steer);
      wr(3'd0, TABLE[k].en);
      idle(6);
      wr(3'd1, 32'hFFFF_FFFF);
      src_i = TABLE[k].src1;
      idle(6);
      #1;
      m  = TABLE[k].raw & TABLE[k].en;
      pn = m & ~TABLE[k].steer;
      tb = top_bit(pn);
      chk($sformatf("R6 irq row %0d", k), 32'(irq_o), 32'(|pn));
      chk($sformatf("R6 fiq row %0d", k), 32'(fiq_o), 32'(|(m & TABLE[k].steer)));
      chk($sformatf("R7 valid row %0d", k), 32'(vec_valid_o), 32'(tb[5]));
      chk($sformatf("R7 vec row %0d", k), 32'(vec_o), 32'(tb[4:0]));
      rd(3'd1, d); chk($sformatf("R2 R3 raw row %0d", k), d, TABLE[k].raw);
      rd(3'd2, d); chk($sformatf("R5 masked row %0d", k), d, m);
    end

    // R3 sticky edge, R4 clears
    wr(3'd3, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    @(negedge clk) src_i = '0;
    idle(6);
    wr(3'd1, 32'hFFFF_FFFF);
    src_i = 32'h0000_0030;
    idle(6);
    @(negedge clk) src_i = '0;
    idle(6);
    rd(3'd1, d); chk("R3 sticky after release", d, 32'h0000_0030);
    #1 chk("R3 irq held", 32'(irq_o), 32'd1);
    wr(3'd1, 32'h0000_0010);
    rd(3'd1, d); chk("R4 partial clear", d, 32'h0000_0020);
    wr(3'd1, 32'h0);
    rd(3'd1, d); chk("R4 zero write keeps", d, 32'h0000_0020);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R4 masked write no raw effect", d, 32'h0000_0020);
    rd(3'd0, d); chk("R4 masked write no enable effect", d, 32'hFFFF_FFFF);

    // R4 level bit unaffected by clear
    wr(3'd4, 32'h0);
    @(negedge clk) src_i = 32'h0000_0001;
    idle(6);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R4 level not cleared", d, 32'h0000_0001);

    // R7 / R2 timing: level source on bit 8
    @(negedge clk) src_i = '0;
    idle(6);
    @(negedge clk) src_i = 32'h0000_0100;
    @(posedge clk); #1 chk("R2 not yet after one edge", 32'(irq_o), 32'd0);
    @(posedge clk); #1 chk("R2 irq after two edges", 32'(irq_o), 32'd1);
    chk("R7 valid lags irq", 32'(vec_valid_o), 32'd0);
    @(posedge clk); #1 chk("R7 valid one edge later", 32'(vec_valid_o), 32'd1);
    chk("R7 vec index", 32'(vec_o), 32'd8);

    // R8 unmapped words read zero
    rd(3'd6, d); chk("R8 word 6", d, 32'h0);
    rd(3'd7, d); chk("R8 word 7", d, 32'h0);
    rd(3'd5, d); chk("R8 steer readback", d, 32'h0);

    finish_run();
  end
endmodule